// File: doc/BRIEF.md
# Partition-Tagged Translation Table with Invalidation Commands

This block is a fully associative address translation table. Each slot maps one virtual page to a physical page. The page can be one of several sizes, selected by a size code. Every slot carries three tags: a partition number, a context number and a flag for real (untranslated-context) mappings. A slot can also be pinned with a lock bit.

A single command port changes the table. It can write a new mapping, or remove mappings in one of four ways:
- by address,
- by context,
- by partition (sparing pinned slots),
- all slots, pinned or not.

A separate lookup port is purely combinational. It returns whether a slot matched, which slot matched, the translated physical address and that slot's lock bit.

Any accepted table-changing command raises a one-cycle flush output on the following cycle. A small translation cache in front of the table can use it to drop whatever it holds. Commands are taken one per clock. The lookup port always reflects the table as it stood before the clock edge that applies the current command.

Top module: `tlb_top`

## Requirements
- R1: `NUM_ENTRIES` lies in 1..64, and a value outside that range stops elaboration. Slots are numbered 0..NUM_ENTRIES-1, and all of them can hold a mapping at the same time.
- R2: A lookup hits a slot only when all of these hold: the slot is valid, the partition is equal, the real flag is equal, and the virtual address lies inside the slot's page. The page spans 2^(12+3*size) bytes, where size is a 2-bit code. The physical result takes the page bits from the slot and the offset bits from the lookup address.
- R3: A lookup with the real flag clear also requires an equal context. A lookup with the real flag set ignores the context.
- R4: When several slots match one lookup, the lowest-numbered slot is reported.
- R5: Insert (opcode 0) writes the lowest-numbered invalid slot.
- R6: Insert into a full table overwrites the first unlocked slot at or after a round-robin pointer. The pointer starts at 0 and moves to just past the overwritten slot. If every slot is locked, the insert is dropped.
- R7: Demap page (opcode 1) invalidates every slot that a lookup with the command's address, partition, context and real flag would hit.
- R8: Demap context (opcode 2) invalidates every valid slot whose partition and context both equal the operands, locked or not.
- R9: Demap partition (opcode 3) invalidates every unlocked slot of the given partition. Locked slots of that partition, and all slots of other partitions, stay.
- R10: Invalidate all (opcode 4) clears every slot, including locked ones.
- R11: Each accepted command with opcode 0..4 raises `flushOut` for exactly the cycle after its accepting edge. Opcodes 5..7 change nothing and raise no flush.
- R12: `cmdReady` is high whenever the block is out of reset. A lookup presented in the same cycle as a command sees the table contents from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; empties the table |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command can be taken this cycle |
| cmdOp | input | 3 | Opcode (0 insert, 1 demap page, 2 demap context, 3 demap partition, 4 invalidate all) |
| cmdVa | input | VA_W | Virtual address operand |
| cmdPart | input | PART_W | Partition operand |
| cmdCtx | input | CTX_W | Context operand |
| cmdReal | input | 1 | Real-mapping flag operand |
| cmdLocked | input | 1 | Lock bit for insert |
| cmdSize | input | 2 | Page size code for insert |
| cmdPa | input | PA_W | Physical page address for insert |
| lkVa | input | VA_W | Lookup virtual address |
| lkPart | input | PART_W | Lookup partition |
| lkCtx | input | CTX_W | Lookup context |
| lkReal | input | 1 | Lookup real flag |
| lkHit | output | 1 | A slot matched |
| lkIdx | output | IDX_W | Index of the matching slot |
| lkPaddr | output | PA_W | Translated physical address |
| lkLocked | output | 1 | Lock bit of the matching slot |
| flushOut | output | 1 | One-cycle flush to a front-end translation cache |

## Verification
A lookup and a table-changing command can fall in the same cycle. The bench provokes this by driving an insert, and later a demap, while the lookup inputs already target the affected page. It samples the lookup outputs before the edge and expects the old result: a miss for the insert, a hit for the demap. It samples again after the edge and expects the new result. The flush pulse is judged on the same commands: high on the first cycle after acceptance, low on the next, and absent for the unused opcodes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int MAX_ENTRIES = 64;
  localparam int MAX_IDX_W   = 6;

  typedef enum logic [2:0] {
    OP_INSERT     = 3'd0,
    OP_DEMAP_PAGE = 3'd1,
    OP_DEMAP_CTX  = 3'd2,
    OP_DEMAP_PART = 3'd3,
    OP_INV_ALL    = 3'd4
  } tlbOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;
    logic [MAX_IDX_W-1:0] wrIdx;
    logic                 clrPage;
    logic                 clrCtx;
    logic                 clrPart;
    logic                 clrAll;
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PART_W      = 8,
  parameter int CTX_W       = 16,
  parameter int BASE_SHIFT  = 12,
  parameter int SZ_STEP     = 3,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int OFF_W      = BASE_SHIFT + SZ_STEP * 3
) (
  input  logic              clk,
  input  logic              rst,
  input  tlbStrobe_t        strobe,
  input  logic [VA_W-1:0]   cmdVa,
  input  logic [PART_W-1:0] cmdPart,
  input  logic [CTX_W-1:0]  cmdCtx,
  input  logic              cmdReal,
  input  logic              cmdLocked,
  input  logic [1:0]        cmdSize,
  input  logic [PA_W-1:0]   cmdPa,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [PART_W-1:0] lkPart,
  input  logic [CTX_W-1:0]  lkCtx,
  input  logic              lkReal,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [NUM_ENTRIES-1:0] lockedVec,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [PA_W-1:0]   lkPaddr,
  output logic              lkLocked
);
  logic [NUM_ENTRIES-1:0] entValid;
  logic [VA_W-1:0]   entVa   [NUM_ENTRIES];
  logic [PA_W-1:0]   entPa   [NUM_ENTRIES];
  logic [PART_W-1:0] entPart [NUM_ENTRIES];
  logic [CTX_W-1:0]  entCtx  [NUM_ENTRIES];
  logic              entReal [NUM_ENTRIES];
  logic              entLock [NUM_ENTRIES];
  logic [1:0]        entSz   [NUM_ENTRIES];

  logic [VA_W-1:0]   vaMask  [NUM_ENTRIES];
  logic [PA_W-1:0]   paMask  [NUM_ENTRIES];
  logic [PA_W-1:0]   entXlat [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] lkMatch, cmdPageHit, cmdCtxHit, cmdPartHit;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    assign vaMask[i] = {VA_W{1'b1}} << (BASE_SHIFT + SZ_STEP * int'(entSz[i]));
    assign paMask[i] = {PA_W{1'b1}} << (BASE_SHIFT + SZ_STEP * int'(entSz[i]));

    assign lkMatch[i] = entValid[i] && (entPart[i] == lkPart) &&
                        (entReal[i] == lkReal) && (lkReal || entCtx[i] == lkCtx) &&
                        (((entVa[i] ^ lkVa) & vaMask[i]) == '0);
    assign cmdPageHit[i] = entValid[i] && (entPart[i] == cmdPart) &&
                           (entReal[i] == cmdReal) && (cmdReal || entCtx[i] == cmdCtx) &&
                           (((entVa[i] ^ cmdVa) & vaMask[i]) == '0);
    assign cmdCtxHit[i]  = entValid[i] && (entPart[i] == cmdPart) && (entCtx[i] == cmdCtx);
    assign cmdPartHit[i] = entValid[i] && (entPart[i] == cmdPart) && !entLock[i];

    assign entXlat[i] = (entPa[i] & paMask[i]) |
                        PA_W'(lkVa[OFF_W-1:0] & ~vaMask[i][OFF_W-1:0]);

    assign validVec[i]  = entValid[i];
    assign lockedVec[i] = entValid[i] && entLock[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        entValid[i] <= 1'b0;
      end else if (strobe.wrEn && strobe.wrIdx == MAX_IDX_W'(i)) begin
        entValid[i] <= 1'b1;
      end else if (strobe.clrAll ||
                   (strobe.clrPage && cmdPageHit[i]) ||
                   (strobe.clrCtx  && cmdCtxHit[i])  ||
                   (strobe.clrPart && cmdPartHit[i])) begin
        entValid[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.wrEn && strobe.wrIdx == MAX_IDX_W'(i)) begin
        entVa[i]   <= cmdVa;
        entPa[i]   <= cmdPa;
        entPart[i] <= cmdPart;
        entCtx[i]  <= cmdCtx;
        entReal[i] <= cmdReal;
        entLock[i] <= cmdLocked;
        entSz[i]   <= cmdSize;
      end
    end
  end

  // lowest matching index wins
  always_comb begin
    lkHit    = 1'b0;
    lkIdx    = '0;
    lkPaddr  = '0;
    lkLocked = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) begin
        lkHit    = 1'b1;
        lkIdx    = IDX_W'(i);
        lkPaddr  = entXlat[i];
        lkLocked = entLock[i];
      end
    end
  end
endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmdValid,
  input  logic [2:0]             cmdOp,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic [NUM_ENTRIES-1:0] lockedVec,
  output logic                   cmdReady,
  output tlbStrobe_t             strobe,
  output logic                   flushOut
);
  logic             accept;
  logic             freeFound, vicFound;
  logic [IDX_W-1:0] freeIdx, vicIdx, rrPtr;

  assign cmdReady = 1'b1;
  assign accept   = cmdValid;

  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
    vicFound = 1'b0;
    vicIdx   = '0;
    for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
      if (!lockedVec[(int'(rrPtr) + k) % NUM_ENTRIES]) begin
        vicFound = 1'b1;
        vicIdx   = IDX_W'((int'(rrPtr) + k) % NUM_ENTRIES);
      end
    end
  end

  always_comb begin
    strobe = '0;
    if (accept) begin
      case (cmdOp)
        OP_INSERT: begin
          strobe.wrEn  = freeFound || vicFound;
          strobe.wrIdx = MAX_IDX_W'(freeFound ? freeIdx : vicIdx);
        end
        OP_DEMAP_PAGE: strobe.clrPage = 1'b1;
        OP_DEMAP_CTX:  strobe.clrCtx  = 1'b1;
        OP_DEMAP_PART: strobe.clrPart = 1'b1;
        OP_INV_ALL:    strobe.clrAll  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rrPtr    <= '0;
      flushOut <= 1'b0;
    end else begin
      flushOut <= accept && (cmdOp <= OP_INV_ALL);
      if (accept && cmdOp == OP_INSERT && !freeFound && vicFound)
        rrPtr <= (vicIdx == IDX_W'(NUM_ENTRIES - 1)) ? '0 : vicIdx + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PART_W      = 8,
  parameter int CTX_W       = 16,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [VA_W-1:0]   cmdVa,
  input  logic [PART_W-1:0] cmdPart,
  input  logic [CTX_W-1:0]  cmdCtx,
  input  logic              cmdReal,
  input  logic              cmdLocked,
  input  logic [1:0]        cmdSize,
  input  logic [PA_W-1:0]   cmdPa,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [PART_W-1:0] lkPart,
  input  logic [CTX_W-1:0]  lkCtx,
  input  logic              lkReal,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [PA_W-1:0]   lkPaddr,
  output logic              lkLocked,
  output logic              flushOut
);
  if (NUM_ENTRIES < 1 || NUM_ENTRIES > MAX_ENTRIES) begin : g_bad_size
    $error("tlb_top: NUM_ENTRIES must be within 1..64");
  end

  tlbStrobe_t             strobe;
  logic [NUM_ENTRIES-1:0] validVec, lockedVec;

  tlb_control #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk, .rst, .cmdValid, .cmdOp, .validVec, .lockedVec,
    .cmdReady, .strobe, .flushOut
  );

  tlb_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .VA_W(VA_W), .PA_W(PA_W),
    .PART_W(PART_W), .CTX_W(CTX_W)
  ) u_dp (
    .clk, .rst, .strobe,
    .cmdVa, .cmdPart, .cmdCtx, .cmdReal, .cmdLocked, .cmdSize, .cmdPa,
    .lkVa, .lkPart, .lkCtx, .lkReal,
    .validVec, .lockedVec, .lkHit, .lkIdx, .lkPaddr, .lkLocked
  );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PART_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [2:0]        cmdOp,
  input logic [PART_W-1:0] cmdPart,
  input logic [VA_W-1:0]   lkVa,
  input logic [PART_W-1:0] lkPart,
  input logic              lkHit,
  input logic [PA_W-1:0]   lkPaddr,
  input logic              lkLocked,
  input logic              flushOut
);
  assert_flush_after_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdReady && cmdOp <= 3'd4) |=> flushOut);

  assert_no_flush_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !(cmdValid && cmdReady && cmdOp <= 3'd4) |=> !flushOut);

  assert_inv_all_empties_R10: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdReady && cmdOp == 3'd4) |=> !lkHit);

  assert_demap_part_spares_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdReady && cmdOp == 3'd3) |=>
      (!(lkHit && lkPart == $past(cmdPart)) || lkLocked));

  assert_page_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    lkHit |-> (lkPaddr[11:0] == lkVa[11:0]));
endmodule

bind tlb_top tlb_checker #(.VA_W(VA_W), .PA_W(PA_W), .PART_W(PART_W)) u_chk (
  .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
  .cmdPart(cmdPart), .lkVa(lkVa), .lkPart(lkPart), .lkHit(lkHit),
  .lkPaddr(lkPaddr), .lkLocked(lkLocked), .flushOut(flushOut)
);

// File: tb/tlb_top_test.sv
module tlb_top_test;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [2:0]  cmdOp = '0;
  logic [31:0] cmdVa = '0, cmdPa = '0, lkVa = '0;
  logic [7:0]  cmdPart = '0, lkPart = '0;
  logic [15:0] cmdCtx = '0, lkCtx = '0;
  logic        cmdReal = 1'b0, cmdLocked = 1'b0, lkReal = 1'b0;
  logic [1:0]  cmdSize = '0;
  logic        lkHit, lkLocked, flushOut;
  logic [1:0]  lkIdx;
  logic [31:0] lkPaddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tlb_top #(.NUM_ENTRIES(N)) uut (
    .clk, .rst, .cmdValid, .cmdReady, .cmdOp, .cmdVa, .cmdPart, .cmdCtx,
    .cmdReal, .cmdLocked, .cmdSize, .cmdPa, .lkVa, .lkPart, .lkCtx, .lkReal,
    .lkHit, .lkIdx, .lkPaddr, .lkLocked, .flushOut
  );

  function automatic logic [31:0] xlat(logic [31:0] pa, logic [31:0] va, int sz);
    logic [31:0] m;
    m = 32'hFFFF_FFFF << (12 + 3 * sz);
    return (pa & m) | (va & ~m);
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(logic [2:0] op, logic [31:0] va, logic [7:0] part,
                     logic [15:0] ctx, logic r, logic lk, logic [1:0] sz,
                     logic [31:0] pa);
    @(negedge clk);
    cmdOp = op; cmdVa = va; cmdPart = part; cmdCtx = ctx;
    cmdReal = r; cmdLocked = lk; cmdSize = sz; cmdPa = pa; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check(flushOut == (op <= 3'd4), "R11 flush after command", flushOut, (op <= 3'd4));
    @(negedge clk);
    check(flushOut == 1'b0, "R11 flush one cycle", flushOut, 0);
  endtask

  task automatic look(logic [31:0] va, logic [7:0] part, logic [15:0] ctx,
                      logic r, bit expHit, int expIdx, logic [31:0] expPa,
                      string tag);
    lkVa = va; lkPart = part; lkCtx = ctx; lkReal = r;
    #0.5;
    check(lkHit == expHit, tag, lkHit, expHit);
    if (expHit && lkHit) begin
      check(int'(lkIdx) == expIdx, tag, lkIdx, expIdx);
      check(lkPaddr == expPa, tag, lkPaddr, expPa);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    look(32'h1000, 8'd1, 16'd5, 1'b0, 0, 0, 0, "R12 reset empty");
    check(flushOut == 0, "R11 reset flush low", flushOut, 0);
    check(cmdReady == 1, "R12 ready high", cmdReady, 1);

    // fill with different sizes/tags (R5, R2)
    cmd(3'd0, 32'h1000, 8'd1, 16'd5, 1'b0, 1'b1, 2'd0, 32'h80000);
    cmd(3'd0, 32'h20000, 8'd1, 16'd5, 1'b0, 1'b0, 2'd1, 32'h48000);
    cmd(3'd0, 32'h3000, 8'd1, 16'd0, 1'b1, 1'b0, 2'd0, 32'h90000);
    look(32'h1234, 8'd1, 16'd5, 1'b0, 1, 0, xlat(32'h80000, 32'h1234, 0), "R5 slot0 R2 small page");
    look(32'h25678, 8'd1, 16'd5, 1'b0, 1, 1, xlat(32'h48000, 32'h25678, 1), "R5 slot1 R2 large page");
    look(32'h28000, 8'd1, 16'd5, 1'b0, 0, 0, 0, "R2 past large page end");
    look(32'h3ABC, 8'd1, 16'd7, 1'b1, 1, 2, xlat(32'h90000, 32'h3ABC, 0), "R3 real ignores context");
    look(32'h3ABC, 8'd1, 16'd0, 1'b0, 0, 0, 0, "R2 real flag must match");
    look(32'h1234, 8'd1, 16'd6, 1'b0, 0, 0, 0, "R3 context mismatch misses");
    look(32'h1234, 8'd2, 16'd5, 1'b0, 0, 0, 0, "R2 partition mismatch misses");

    // same-cycle insert and lookup (R12)
    @(negedge clk);
    cmdOp = 3'd0; cmdVa = 32'h5000; cmdPart = 8'd2; cmdCtx = 16'd9;
    cmdReal = 0; cmdLocked = 0; cmdSize = 0; cmdPa = 32'hB0000; cmdValid = 1;
    look(32'h5010, 8'd2, 16'd9, 1'b0, 0, 0, 0, "R12 insert not yet visible");
    @(negedge clk);
    cmdValid = 0;
    look(32'h5010, 8'd2, 16'd9, 1'b0, 1, 3, 32'hB0010, "R12 insert visible after edge");

    // full: round robin skips locked slot 0 (R6), duplicate -> lowest wins (R4)
    cmd(3'd0, 32'h1000, 8'd1, 16'd5, 1'b0, 1'b0, 2'd0, 32'hA0000);
    look(32'h25678, 8'd1, 16'd5, 1'b0, 0, 0, 0, "R6 slot1 replaced");
    look(32'h1004, 8'd1, 16'd5, 1'b0, 1, 0, 32'h80004, "R4 lowest index wins");
    cmd(3'd0, 32'h6000, 8'd3, 16'd1, 1'b0, 1'b0, 2'd0, 32'hC0000);
    look(32'h3000, 8'd1, 16'd0, 1'b1, 0, 0, 0, "R6 slot2 replaced next");
    look(32'h6000, 8'd3, 16'd1, 1'b0, 1, 2, 32'hC0000, "R6 new entry in slot2");

    // demap page removes both duplicates (R7)
    cmd(3'd1, 32'h1800, 8'd1, 16'd5, 1'b0, 1'b0, 2'd0, 32'h0);
    look(32'h1004, 8'd1, 16'd5, 1'b0, 0, 0, 0, "R7 demap page");
    look(32'h6000, 8'd3, 16'd1, 1'b0, 1, 2, 32'hC0000, "R7 other page kept");

    // first free slot reuse (R5)
    cmd(3'd0, 32'h7000, 8'd2, 16'd9, 1'b0, 1'b1, 2'd0, 32'hD0000);
    cmd(3'd0, 32'h8000, 8'd2, 16'd4, 1'b0, 1'b0, 2'd0, 32'hE0000);
    look(32'h7000, 8'd2, 16'd9, 1'b0, 1, 0, 32'hD0000, "R5 free slot0 reused");
    look(32'h8000, 8'd2, 16'd4, 1'b0, 1, 1, 32'hE0000, "R5 free slot1 reused");

    // demap context, locked included (R8)
    cmd(3'd2, 32'h0, 8'd2, 16'd9, 1'b0, 1'b0, 2'd0, 32'h0);
    look(32'h5000, 8'd2, 16'd9, 1'b0, 0, 0, 0, "R8 context slot3 gone");
    look(32'h7000, 8'd2, 16'd9, 1'b0, 0, 0, 0, "R8 locked context slot gone");
    look(32'h8000, 8'd2, 16'd4, 1'b0, 1, 1, 32'hE0000, "R8 other context kept");

    // demap partition spares locked (R9)
    cmd(3'd0, 32'h7000, 8'd2, 16'd9, 1'b0, 1'b1, 2'd0, 32'hD0000);
    cmd(3'd0, 32'h9000, 8'd3, 16'd1, 1'b0, 1'b1, 2'd0, 32'hF0000);
    cmd(3'd3, 32'h0, 8'd3, 16'd0, 1'b0, 1'b0, 2'd0, 32'h0);
    look(32'h6000, 8'd3, 16'd1, 1'b0, 0, 0, 0, "R9 unlocked slot gone");
    look(32'h9000, 8'd3, 16'd1, 1'b0, 1, 3, 32'hF0000, "R9 locked slot spared");
    check(lkLocked == 1, "R9 spared slot locked", lkLocked, 1);
    look(32'h8000, 8'd2, 16'd4, 1'b0, 1, 1, 32'hE0000, "R9 other partition kept");

    // same-cycle demap and lookup (R12)
    @(negedge clk);
    cmdOp = 3'd1; cmdVa = 32'h8000; cmdPart = 8'd2; cmdCtx = 16'd4; cmdReal = 0; cmdValid = 1;
    look(32'h8000, 8'd2, 16'd4, 1'b0, 1, 1, 32'hE0000, "R12 demap not yet visible");
    @(negedge clk);
    cmdValid = 0;
    look(32'h8000, 8'd2, 16'd4, 1'b0, 0, 0, 0, "R12 demap visible after edge");

    // unused opcode (R11)
    cmd(3'd6, 32'h9000, 8'd3, 16'd1, 1'b0, 1'b0, 2'd0, 32'h0);
    look(32'h9000, 8'd3, 16'd1, 1'b0, 1, 3, 32'hF0000, "R11 unused opcode no change");

    // invalidate all, locked included (R10)
    cmd(3'd4, 32'h0, 8'd0, 16'd0, 1'b0, 1'b0, 2'd0, 32'h0);
    look(32'h7000, 8'd2, 16'd9, 1'b0, 0, 0, 0, "R10 locked slot0 cleared");
    look(32'h9000, 8'd3, 16'd1, 1'b0, 0, 0, 0, "R10 locked slot3 cleared");

    // fill all slots locked, sweep boundaries (R1), then dropped insert (R6)
    for (int i = 0; i < N; i++)
      cmd(3'd0, 32'h10000 + 32'h1000 * i, 8'd1, 16'd1, 1'b0, 1'b1, 2'd0, 32'h100000 * (i + 1));
    for (int i = 0; i < N; i++) begin
      look(32'h10000 + 32'h1000 * i, 8'd1, 16'd1, 1'b0, 1, i, 32'h100000 * (i + 1), "R1 slot low edge");
      look(32'h10FFF + 32'h1000 * i, 8'd1, 16'd1, 1'b0, 1, i,
           32'h100000 * (i + 1) + 32'hFFF, "R1 slot high edge");
    end
    cmd(3'd0, 32'h20000, 8'd1, 16'd1, 1'b0, 1'b0, 2'd0, 32'h700000);
    look(32'h20000, 8'd1, 16'd1, 1'b0, 0, 0, 0, "R6 all locked insert dropped");
    look(32'h10000, 8'd1, 16'd1, 1'b0, 1, 0, 32'h100000, "R6 locked slot0 intact");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule